// File: doc/BRIEF.md
# Serial Channel with Pointer-Addressed Mode Registers

A single asynchronous serial channel that a host controls through a small byte-wide register port. The port uses three active-low strobes: chip-enable, read and write. An access takes effect in the first clock cycle in which chip-enable is low together with a read or write strobe. Holding the strobes low for longer does not repeat the access.

Two mode registers share one address. An internal pointer decides which of them an access reaches, and a command code brings the pointer back to the first one. Every access to the command register opens a short recovery window. An access that arrives inside that window is dropped and raises a sticky error flag.

The transmitter buffers up to two characters ahead of its shift register. Both serial engines run from a 16x bit clock, and each direction chooses its own source for it: a fixed divider of the device clock, or a programmable timer. The block sends and receives 8N1 frames, least significant bit first.

The transmit engine has four states: TX_IDLE, TX_START, TX_DATA and TX_STOP. It moves from TX_IDLE to TX_START on a 16x tick when it is enabled and the buffer holds a character. Every other state advances after its sixteenth tick. TX_DATA repeats for eight bits before it moves to TX_STOP, and TX_STOP returns to TX_IDLE.

The receive engine has five states: RX_IDLE, RX_START, RX_DATA, RX_STOP and RX_HOLD. It moves from RX_IDLE to RX_START when it sees the line low on a tick while it is enabled. In RX_START it looks at the line again at the eighth tick. If the line is high it goes back to RX_IDLE; if it is still low it moves on to RX_DATA. RX_DATA samples each bit at the sixteenth tick and moves to RX_STOP after eight bits. RX_STOP samples the stop bit at its sixteenth tick. A high stop bit returns the engine to RX_IDLE. A low stop bit sends it to RX_HOLD, which waits for the line to go high before it returns to RX_IDLE.

Top module: `uptr_chan`

## Requirements
- R1: After reset the pointer selects mode register 1, the transmit buffer is empty, both directions are disabled, txd is 1, irq is 0 and status reads 0x06. Status bits are: bit0 receive data ready, bit1 transmit buffer has space, bit2 transmitter fully empty, bit3 framing error, bit4 access error.
- R2: Address 0 reaches mode register 1 on the first accepted access after a pointer reset. Every later accepted access, read or write, reaches mode register 2.
- R3: A command write (address 2) with bits [6:4] = 001, for example 0x10, returns the pointer to mode register 1. In the same byte, bit0 enables the receiver, bit1 disables it, bit2 enables the transmitter and bit3 disables it.
- R4: Any access to address 2 blocks every access in the next 3 clock cycles. A blocked access changes no register and sets status bit4. An accepted read of status (address 1) clears bit4 and bit3.
- R5: A read or write strobe with cs_n high has no effect.
- R6: The transmit buffer holds two characters, written through address 3. Status bit1 stays 1 until both slots are full. A write to a full buffer is ignored.
- R7: The transmitter sends 8N1 frames, least significant bit first, with 16 ticks per bit. While the transmitter is disabled, buffered characters stay in the buffer.
- R8: The receiver assembles 8N1 frames, sets status bit0 and returns the byte on a read of address 3. That read clears bit0.
- R9: A start bit that is high again at its eighth tick is discarded, and no data is reported.
- R10: A low stop bit sets status bit3, does not set bit0, and the receiver waits for the line to go high before it looks for a new start bit.
- R11: Auxiliary register (address 4) bit0 selects the timer as the receive clock and bit1 selects it for the transmit clock. The timer period is {addr 6, addr 5} + 1 device clocks per tick. The divider gives a tick every BRG_DIV clocks.
- R12: Auxiliary bit3 set stops both 16x clocks, so no serial activity takes place.
- R13: irq is 1 exactly when (mode register 1 bit7 and status bit1) or (mode register 1 bit6 and status bit0).
- R14: While the receiver is disabled, incoming frames are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock |
| rst_n | input | 1 | Active-low reset |
| cs_n | input | 1 | Active-low chip enable |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| addr | input | 3 | Register select |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, registered at the accepted read |
| rxd | input | 1 | Serial input |
| txd | output | 1 | Serial output |
| irq | output | 1 | Interrupt request, active high |

## Verification
The bench builds the block with BRG_DIV = 2, so one bit lasts 32 clocks. At that bit length, complete frames, back-to-back transmit frames and a long power-down hold all fit comfortably within the run. The timer is loaded with 3, which gives 64 clocks per bit, so switching clock sources shows up as a clearly different bit length. REC_CYC and FIFO_DEPTH keep their defaults of 3 and 2. The bench can therefore probe both edges of the recovery window and fill the buffer until a third write overflows it.

// File: rtl/uptr_pkg.sv
package uptr_pkg;
    localparam int ADDR_W = 3;
    localparam logic [ADDR_W-1:0] A_MODE = 3'd0;
    localparam logic [ADDR_W-1:0] A_STAT = 3'd1;
    localparam logic [ADDR_W-1:0] A_CMD  = 3'd2;
    localparam logic [ADDR_W-1:0] A_DATA = 3'd3;
    localparam logic [ADDR_W-1:0] A_AUX  = 3'd4;
    localparam logic [ADDR_W-1:0] A_TLO  = 3'd5;
    localparam logic [ADDR_W-1:0] A_THI  = 3'd6;

    typedef enum logic [1:0] {TX_IDLE, TX_START, TX_DATA, TX_STOP} tx_st_t;
    typedef enum logic [2:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP, RX_HOLD} rx_st_t;
endpackage

// File: rtl/uptr_tick.sv
module uptr_tick #(
    parameter int BRG_DIV = 12,
    parameter int TMR_W   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pd,
    input  logic             rx_sel,
    input  logic             tx_sel,
    input  logic [TMR_W-1:0] tmr_load,
    output logic             rx_tick,
    output logic             tx_tick
);
    localparam int DW = (BRG_DIV > 1) ? $clog2(BRG_DIV) : 1;

    logic [DW-1:0]    div_q;
    logic [TMR_W-1:0] tmr_q;
    logic             brg_hit, tmr_hit;

    assign brg_hit = (div_q == DW'(BRG_DIV - 1));
    assign tmr_hit = (tmr_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
            tmr_q <= '0;
        end else if (!pd) begin
            div_q <= brg_hit ? '0 : div_q + 1'b1;
            tmr_q <= tmr_hit ? tmr_load : tmr_q - 1'b1;
        end
    end

    assign rx_tick = !pd && (rx_sel ? tmr_hit : brg_hit);
    assign tx_tick = !pd && (tx_sel ? tmr_hit : brg_hit);
endmodule

// File: rtl/uptr_fifo.sv
module uptr_fifo #(
    parameter int DEPTH = 2,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic         full,
    output logic         empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          do_push, do_pop;

    assign full    = (cnt == CW'(DEPTH));
    assign empty   = (cnt == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rp];

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= bump(wp);
            if (do_pop)  rp <= bump(rp);
            cnt <= cnt + CW'(do_push) - CW'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
    end

    // R6: the occupancy never exceeds the depth, and a push into a full buffer leaves it full
    a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> full);
    a_r6_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(DEPTH));
endmodule

// File: rtl/uptr_tx.sv
module uptr_tx import uptr_pkg::*; (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       en,
    input  logic       have,
    input  logic [7:0] din,
    output logic       pop,
    output logic       txd,
    output logic       idle
);
    tx_st_t     st, nxt;
    logic [3:0] cnt;
    logic [2:0] bitn;
    logic [7:0] sh;

    always_comb begin
        nxt = st;
        unique case (st)
            TX_IDLE:  if (tick && en && have) nxt = TX_START;
            TX_START: if (tick && cnt == 4'd15) nxt = TX_DATA;
            TX_DATA:  if (tick && cnt == 4'd15 && bitn == 3'd7) nxt = TX_STOP;
            TX_STOP:  if (tick && cnt == 4'd15) nxt = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st   <= TX_IDLE;
            cnt  <= '0;
            bitn <= '0;
            sh   <= '0;
        end else begin
            st <= nxt;
            if (st == TX_IDLE) begin
                if (pop) begin
                    sh   <= din;
                    cnt  <= '0;
                    bitn <= '0;
                end
            end else if (tick) begin
                cnt <= cnt + 1'b1;
                if (st == TX_DATA && cnt == 4'd15) begin
                    sh   <= sh >> 1;
                    bitn <= bitn + 1'b1;
                end
            end
        end
    end

    always_comb begin
        pop  = (st == TX_IDLE) && (nxt == TX_START);
        idle = (st == TX_IDLE);
        unique case (st)
            TX_IDLE:  txd = 1'b1;
            TX_START: txd = 1'b0;
            TX_DATA:  txd = sh[0];
            TX_STOP:  txd = 1'b1;
        endcase
    end

    // R7: leaving idle always begins with a low start bit
    a_r7_frame_starts_low: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(idle) |-> !txd);
endmodule

// File: rtl/uptr_rx.sv
module uptr_rx import uptr_pkg::*; (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       en,
    input  logic       rxd_s,
    output logic       got,
    output logic       bad,
    output logic [7:0] dout
);
    rx_st_t     st, nxt;
    logic [3:0] cnt;
    logic [2:0] bitn;

    always_comb begin
        nxt = st;
        unique case (st)
            RX_IDLE:  if (tick && en && !rxd_s) nxt = RX_START;
            RX_START: if (tick && cnt == 4'd7) nxt = rxd_s ? RX_IDLE : RX_DATA;
            RX_DATA:  if (tick && cnt == 4'd15 && bitn == 3'd7) nxt = RX_STOP;
            RX_STOP:  if (tick && cnt == 4'd15) nxt = rxd_s ? RX_IDLE : RX_HOLD;
            RX_HOLD:  if (rxd_s) nxt = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st   <= RX_IDLE;
            cnt  <= '0;
            bitn <= '0;
            dout <= '0;
        end else begin
            st <= nxt;
            if (st == RX_IDLE || (st == RX_START && nxt == RX_DATA)) begin
                cnt  <= '0;
                bitn <= '0;
            end else if (tick) begin
                cnt <= cnt + 1'b1;
                if (st == RX_DATA && cnt == 4'd15) begin
                    dout <= {rxd_s, dout[7:1]};
                    bitn <= bitn + 1'b1;
                end
            end
        end
    end

    always_comb begin
        got = (st == RX_STOP) && (nxt == RX_IDLE);
        bad = (st == RX_STOP) && (nxt == RX_HOLD);
    end

    // R10: after a bad stop bit the receiver waits while the line stays low
    a_r10_hold_while_low: assert property (@(posedge clk) disable iff (!rst_n)
        (st == RX_HOLD && !rxd_s) |=> (st == RX_HOLD));
endmodule

// File: rtl/uptr_chan.sv
module uptr_chan import uptr_pkg::*; #(
    parameter int BRG_DIV    = 12,
    parameter int REC_CYC    = 3,
    parameter int FIFO_DEPTH = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       rd_n,
    input  logic       wr_n,
    input  logic [2:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    input  logic       rxd,
    output logic       txd,
    output logic       irq
);
    localparam int RW    = $clog2(REC_CYC + 1);
    localparam int TMR_W = 16;

    logic [7:0]  mr1, mr2, tlo, thi;
    logic        ptr, rx_en, tx_en, sel_rx, sel_tx, pd;
    logic [RW-1:0] rec_q;
    logic        acc_err, frm_err, rx_ready, act_q;
    logic [1:0]  rx_sync;
    logic        act, ev, blocked, ok, wr_ok, rd_ok, cmd_acc;
    logic        rx_tick, tx_tick, f_full, f_empty, tx_pop, tx_idle;
    logic        rx_got, rx_bad;
    logic [7:0]  f_dout, rx_byte, status;
    logic        tx_ready, tx_empty;

    assign act     = !cs_n && (!rd_n || !wr_n);
    assign ev      = act && !act_q;
    assign blocked = (rec_q != '0);
    assign ok      = ev && !blocked;
    assign wr_ok   = ok && !wr_n;
    assign rd_ok   = ok && wr_n;
    assign cmd_acc = ok && (addr == A_CMD);

    assign tx_ready = !f_full;
    assign tx_empty = f_empty && tx_idle;
    assign status   = {3'b000, acc_err, frm_err, tx_empty, tx_ready, rx_ready};

    uptr_tick #(.BRG_DIV(BRG_DIV), .TMR_W(TMR_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .pd(pd), .rx_sel(sel_rx), .tx_sel(sel_tx),
        .tmr_load({thi, tlo}), .rx_tick(rx_tick), .tx_tick(tx_tick));

    uptr_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(wr_ok && addr == A_DATA), .pop(tx_pop),
        .din(wdata), .dout(f_dout), .full(f_full), .empty(f_empty));

    uptr_tx u_tx (
        .clk(clk), .rst_n(rst_n), .tick(tx_tick), .en(tx_en), .have(!f_empty),
        .din(f_dout), .pop(tx_pop), .txd(txd), .idle(tx_idle));

    uptr_rx u_rx (
        .clk(clk), .rst_n(rst_n), .tick(rx_tick), .en(rx_en), .rxd_s(rx_sync[1]),
        .got(rx_got), .bad(rx_bad), .dout(rx_byte));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mr1 <= '0; mr2 <= '0; tlo <= '0; thi <= '0;
            ptr <= 1'b0; rx_en <= 1'b0; tx_en <= 1'b0;
            sel_rx <= 1'b0; sel_tx <= 1'b0; pd <= 1'b0;
            rec_q <= '0; acc_err <= 1'b0; frm_err <= 1'b0; rx_ready <= 1'b0;
            act_q <= 1'b0; rx_sync <= 2'b11; rdata <= '0;
        end else begin
            act_q   <= act;
            rx_sync <= {rx_sync[0], rxd};

            if (cmd_acc)      rec_q <= RW'(REC_CYC);
            else if (blocked) rec_q <= rec_q - 1'b1;

            if (ok && addr == A_MODE) begin
                ptr <= 1'b1;
                if (wr_ok) begin
                    if (ptr) mr2 <= wdata;
                    else     mr1 <= wdata;
                end
            end

            if (wr_ok && addr == A_CMD) begin
                if (wdata[6:4] == 3'b001) ptr <= 1'b0;
                if (wdata[1])      rx_en <= 1'b0;
                else if (wdata[0]) rx_en <= 1'b1;
                if (wdata[3])      tx_en <= 1'b0;
                else if (wdata[2]) tx_en <= 1'b1;
            end

            if (wr_ok && addr == A_AUX) begin
                sel_rx <= wdata[0];
                sel_tx <= wdata[1];
                pd     <= wdata[3];
            end
            if (wr_ok && addr == A_TLO) tlo <= wdata;
            if (wr_ok && addr == A_THI) thi <= wdata;

            if (ev && blocked)                acc_err <= 1'b1;
            else if (rd_ok && addr == A_STAT) acc_err <= 1'b0;

            if (rx_bad)                       frm_err <= 1'b1;
            else if (rd_ok && addr == A_STAT) frm_err <= 1'b0;

            if (rx_got)                       rx_ready <= 1'b1;
            else if (rd_ok && addr == A_DATA) rx_ready <= 1'b0;

            if (rd_ok) begin
                unique case (addr)
                    A_MODE:  rdata <= ptr ? mr2 : mr1;
                    A_STAT:  rdata <= status;
                    A_DATA:  rdata <= rx_byte;
                    A_AUX:   rdata <= {4'b0000, pd, 1'b0, sel_tx, sel_rx};
                    A_TLO:   rdata <= tlo;
                    A_THI:   rdata <= thi;
                    default: rdata <= '0;
                endcase
            end
        end
    end

    always_comb begin
        irq = (mr1[7] && tx_ready) || (mr1[6] && rx_ready);
    end

    // R5: nothing changes while the chip is not selected
    a_r5_no_select: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> ($stable(mr1) && $stable(mr2) && $stable(ptr) && $stable(pd)));
    // R4: a blocked access leaves the mode registers and the pointer intact
    a_r4_blocked_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (ev && blocked) |=> ($stable(mr1) && $stable(mr2) && $stable(ptr)));
    // R2: the pointer stays on mode register 2 until a command access
    a_r2_ptr_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr && !cmd_acc) |=> ptr);
    // R7: the transmitter only takes a character that is present
    a_r7_pop_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop |-> !f_empty);
    // R8: a completed frame leaves data ready
    a_r8_got_sets_ready: assert property (@(posedge clk) disable iff (!rst_n)
        rx_got |=> rx_ready);
    // R10: a bad stop bit raises the framing flag
    a_r10_bad_flags: assert property (@(posedge clk) disable iff (!rst_n)
        rx_bad |=> frm_err);
    // R12: with the clocks stopped the serial output holds
    a_r12_pd_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        (pd && $past(pd)) |-> $stable(txd));
endmodule

// File: tb/uptr_chan_test.sv
module uptr_chan_test;
    localparam int BRG   = 2;
    localparam int BP    = 16 * BRG;
    localparam int BP_T  = 16 * 4;
    localparam logic [2:0] R_MODE = 3'd0, R_STAT = 3'd1, R_CMD = 3'd2, R_DATA = 3'd3,
                           R_AUX = 3'd4, R_TLO = 3'd5, R_THI = 3'd6;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0, rdata;
    logic rxd = 1'b1, txd, irq;

    int checks = 0, errors = 0;
    bit track = 0;
    bit m_tx_ien = 0, m_rx_ien = 0, m_rxr = 0;
    int m_cnt = 0;

    always #5 clk = ~clk;

    uptr_chan #(.BRG_DIV(BRG)) uut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .addr(addr), .wdata(wdata), .rdata(rdata), .rxd(rxd), .txd(txd), .irq(irq));

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // R13 reference model: irq compared on every clock while tracking
    always begin
        @(negedge clk);
        #1;
        if (track) chk("R13 irq model", int'(irq),
                       int'((m_tx_ien && m_cnt < 2) || (m_rx_ien && m_rxr)));
    end

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; wdata = d; cs_n = 1'b0; wr_n = 1'b0;
        @(negedge clk); cs_n = 1'b1; wr_n = 1'b1;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk); addr = a; cs_n = 1'b0; rd_n = 1'b0;
        @(negedge clk); cs_n = 1'b1; rd_n = 1'b1; d = rdata;
    endtask

    task automatic cmd(input logic [7:0] d);
        wr(R_CMD, d);
        repeat (4) @(negedge clk);
    endtask

    task automatic get_tx(input int bp, output logic [8:0] f);
        int t = 0;
        f = 'x;
        while (txd !== 1'b0 && t < 4000) begin @(negedge clk); t++; end
        if (t >= 4000) return;
        repeat (bp / 2) @(negedge clk);
        for (int i = 0; i < 9; i++) begin
            repeat (bp) @(negedge clk);
            f[i] = txd;
        end
    endtask

    task automatic send_rx(input logic [7:0] b, input int bp, input logic stopv);
        @(negedge clk); rxd = 1'b0;
        repeat (bp) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rxd = b[i];
            repeat (bp) @(negedge clk);
        end
        rxd = stopv;
        repeat (bp) @(negedge clk);
        rxd = 1'b1;
        repeat (bp) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] v;
        logic [8:0] f;
        int lows;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        track = 1;

        // R1 reset state
        chk("R1 txd", int'(txd), 1);
        chk("R1 irq", int'(irq), 0);
        rd(R_STAT, v); chk("R1 status", v, 8'h06);

        // R2 pointer walk, R3 pointer reset
        wr(R_MODE, 8'h11); wr(R_MODE, 8'h22); wr(R_MODE, 8'h33);
        cmd(8'h10);
        rd(R_MODE, v); chk("R2 R3 first read hits mode1", v, 8'h11);
        rd(R_MODE, v); chk("R2 second read hits mode2", v, 8'h33);
        rd(R_MODE, v); chk("R2 pointer stays on mode2", v, 8'h33);

        // R5 strobes without chip enable
        @(negedge clk); addr = R_MODE; wdata = 8'h99; wr_n = 1'b0;
        @(negedge clk); wr_n = 1'b1; addr = R_CMD; wdata = 8'h10;
        @(negedge clk); wr_n = 1'b0;
        @(negedge clk); wr_n = 1'b1;
        rd(R_MODE, v); chk("R5 unselected strobes ignored", v, 8'h33);
        cmd(8'h10);
        rd(R_MODE, v); chk("R5 mode1 intact", v, 8'h11);

        // R4 recovery window
        cmd(8'h10);
        wr(R_CMD, 8'h10);
        wr(R_MODE, 8'h55);
        repeat (4) @(negedge clk);
        rd(R_STAT, v); chk("R4 access error flagged", v, 8'h16);
        rd(R_STAT, v); chk("R4 flag cleared by status read", v, 8'h06);
        rd(R_MODE, v); chk("R4 blocked write ignored", v, 8'h11);
        cmd(8'h10);
        wr(R_CMD, 8'h10);
        repeat (2) @(negedge clk);
        wr(R_MODE, 8'h66);
        rd(R_STAT, v); chk("R4 access at window edge accepted", v, 8'h06);

        // R6 / R13 buffer and interrupt
        cmd(8'h10);
        wr(R_MODE, 8'hC0); m_tx_ien = 1; m_rx_ien = 1;
        chk("R13 irq on buffer space", int'(irq), 1);
        wr(R_DATA, 8'h3C); m_cnt = 1;
        rd(R_STAT, v); chk("R6 one held, still ready", v, 8'h02);
        wr(R_DATA, 8'hC3); m_cnt = 2;
        rd(R_STAT, v); chk("R6 two held, not ready", v, 8'h00);
        chk("R13 irq drops when full", int'(irq), 0);
        wr(R_DATA, 8'h77);
        repeat (100) @(negedge clk);
        chk("R7 disabled transmitter keeps line idle", int'(txd), 1);
        track = 0;

        // R7 transmit both buffered frames
        cmd(8'h04);
        get_tx(BP, f); chk("R7 first frame", f, 9'h13C);
        get_tx(BP, f); chk("R7 second frame", f, 9'h1C3);
        repeat (3 * BP) @(negedge clk);
        chk("R6 third write dropped, line idle", int'(txd), 1);
        rd(R_STAT, v); chk("R6 empty after two frames", v, 8'h06);

        // R8 receive
        cmd(8'h01);
        send_rx(8'h5A, BP, 1'b1);
        rd(R_STAT, v); chk("R8 data ready", v, 8'h07);
        rd(R_DATA, v); chk("R8 byte", v, 8'h5A);
        rd(R_STAT, v); chk("R8 ready cleared by read", v, 8'h06);

        // R13 receive interrupt
        cmd(8'h10);
        wr(R_MODE, 8'h40);
        chk("R13 no irq without data", int'(irq), 0);
        send_rx(8'h81, BP, 1'b1);
        chk("R13 irq on receive", int'(irq), 1);
        rd(R_DATA, v); chk("R8 second byte", v, 8'h81);
        chk("R13 irq clears after read", int'(irq), 0);

        // R9 short start pulse
        @(negedge clk); rxd = 1'b0;
        repeat (6) @(negedge clk);
        rxd = 1'b1;
        repeat (12 * BP) @(negedge clk);
        rd(R_STAT, v); chk("R9 glitch rejected", v, 8'h06);

        // R10 framing error
        send_rx(8'h33, BP, 1'b0);
        repeat (BP) @(negedge clk);
        rd(R_STAT, v); chk("R10 framing flagged", v, 8'h0E);
        rd(R_STAT, v); chk("R10 flag cleared", v, 8'h06);
        send_rx(8'hE7, BP, 1'b1);
        rd(R_DATA, v); chk("R10 receiver recovers", v, 8'hE7);

        // R14 receiver disabled
        cmd(8'h02);
        send_rx(8'h44, BP, 1'b1);
        rd(R_STAT, v); chk("R14 disabled receiver ignores", v, 8'h06);

        // R11 timer clock source
        cmd(8'h05);
        wr(R_TLO, 8'h03); wr(R_THI, 8'h00); wr(R_AUX, 8'h03);
        rd(R_AUX, v); chk("R11 aux readback", v, 8'h03);
        repeat (8) @(negedge clk);
        wr(R_DATA, 8'h96);
        get_tx(BP_T, f); chk("R11 transmit on timer", f, 9'h196);
        repeat (BP_T) @(negedge clk);
        send_rx(8'h69, BP_T, 1'b1);
        rd(R_DATA, v); chk("R11 receive on timer", v, 8'h69);

        // R12 power-down
        wr(R_AUX, 8'h08);
        wr(R_DATA, 8'hA5);
        lows = 0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (txd !== 1'b1) lows++;
        end
        chk("R12 no output while stopped", lows, 0);
        rd(R_STAT, v); chk("R12 character still held", v, 8'h02);
        wr(R_AUX, 8'h00);
        get_tx(BP, f); chk("R12 sent after wake", f, 9'h1A5);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule